// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes one redirection request (a destination identifier, an addressing mode, a delivery mode, the source pin number and a vector) and works out which processors of a small cluster receive it. The first stage builds a candidate set from the per-processor presence bits and their physical and logical identifiers. The second stage narrows or replaces that set according to the delivery mode, with pin 0 handled as a special case.

The result appears one clock after the request as a registered recipient bitmask, a non-maskable flag, a delivered indication and the forwarded vector. An interrupt router calls the block once per event it has to send, and fans the bitmask out to the per-processor controllers.

Top module: `intr_dest_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: A request sampled with `req_valid` high produces `res_valid` high on the next edge with its result. A cycle without a request leaves `res_valid`, `res_mask`, `res_nmi`, `res_delivered` and `res_vector` all zero.
- R3: In physical addressing (`dest_logical`=0), a destination of all ones makes every present processor a candidate.
- R4: In physical addressing with any other destination, the only candidate is the lowest-numbered present processor whose physical identifier equals the destination. Other processors with the same identifier are not candidates.
- R5: In logical addressing (`dest_logical`=1), a destination of zero gives no candidates. Any other destination makes a candidate of every present processor whose logical identifier shares at least one set bit with it.
- R6: If the candidate set is empty, the mask is zero, `res_delivered` is 0 and `res_nmi` is 0, whatever the mode and pin.
- R7: Fixed mode (`dlv_mode`=3'b000) on a nonzero pin sends to the whole candidate set.
- R8: Fixed mode on pin 0 with a nonempty candidate set sends only to processor 0, provided processor 0 is present.
- R9: Lowest-priority mode (`dlv_mode`=3'b001) sends to exactly one processor. On a nonzero pin this is the lowest-numbered candidate. On pin 0 it is processor 0, provided processor 0 is present.
- R10: NMI mode (`dlv_mode`=3'b100) sends to the whole candidate set and raises `res_nmi`.
- R11: Every other `dlv_mode` encoding is rejected: mask zero, not delivered, no NMI.
- R12: `res_delivered` is high exactly when the mask is nonzero. `res_vector` then carries the request's vector; otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| dest_id | input | ID_W | Destination identifier |
| dest_logical | input | 1 | 0 physical, 1 logical addressing |
| dlv_mode | input | 3 | Delivery mode encoding |
| src_pin | input | PIN_W | Source pin number |
| vector | input | VEC_W | Interrupt vector |
| cpu_present | input | NUM_CPU | Presence bit per processor |
| cpu_phys_id | input | NUM_CPU*ID_W | Physical identifiers, processor i at bits [i*ID_W +: ID_W] |
| cpu_log_id | input | NUM_CPU*ID_W | Logical identifiers, same packing |
| res_valid | output | 1 | Result strobe |
| res_mask | output | NUM_CPU | Recipient bitmask |
| res_nmi | output | 1 | Result is a non-maskable interrupt |
| res_delivered | output | 1 | At least one recipient |
| res_vector | output | VEC_W | Vector forwarded to the recipients |

## Verification
The bench sweeps every presence pattern against every delivery-mode code, both addressing modes, pin 0 and a nonzero pin, and a set of destinations. The identifiers are chosen so that two processors share a physical identifier and the logical identifiers overlap partly. Shared physical identifiers separate a single-match rule from a match-all rule. Overlapping logical bits separate any-bit matching from exact matching. Absent processors show whether presence gates every path, including the forced pin-0 cases. The all-ones and zero destinations, together with the unused mode codes, cover the broadcast, empty and rejected outcomes.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWEST = 3'b001;
  localparam logic [2:0] DM_NMI    = 3'b100;
endpackage

// File: rtl/dr_first_one.sv
// Keeps only the lowest set bit of the request vector.
module dr_first_one #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot
);
  assign onehot = req & (~req + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/dr_target_match.sv
// Builds the candidate processor set from the destination fields.
module dr_target_match #(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 8
) (
  input  logic [ID_W-1:0]         dest_id,
  input  logic                    dest_logical,
  input  logic [NUM_CPU-1:0]      cpu_present,
  input  logic [NUM_CPU*ID_W-1:0] cpu_phys_id,
  input  logic [NUM_CPU*ID_W-1:0] cpu_log_id,
  output logic [NUM_CPU-1:0]      cand
);
  localparam logic [ID_W-1:0] ALL_ID = {ID_W{1'b1}};

  logic [NUM_CPU-1:0] phys_hit;
  logic [NUM_CPU-1:0] log_hit;
  logic [NUM_CPU-1:0] phys_first;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    assign phys_hit[g] = cpu_present[g] && (cpu_phys_id[g*ID_W +: ID_W] == dest_id);
    assign log_hit[g]  = cpu_present[g] && (|(cpu_log_id[g*ID_W +: ID_W] & dest_id));
  end

  dr_first_one #(.N(NUM_CPU)) u_phys_first (
    .req    (phys_hit),
    .onehot (phys_first)
  );

  always_comb begin
    if (!dest_logical) begin
      cand = (dest_id == ALL_ID) ? cpu_present : phys_first;
    end else begin
      cand = (dest_id == '0) ? '0 : log_hit;
    end
  end
endmodule

// File: rtl/dr_mode_select.sv
// Applies the delivery mode and the pin-0 rules to the candidate set.
module dr_mode_select #(
  parameter int NUM_CPU = 4,
  parameter int PIN_W   = 5
) (
  input  logic [NUM_CPU-1:0] cand,
  input  logic [2:0]         dlv_mode,
  input  logic [PIN_W-1:0]   src_pin,
  input  logic [NUM_CPU-1:0] cpu_present,
  output logic [NUM_CPU-1:0] sel_mask,
  output logic               sel_nmi
);
  import dr_pkg::*;

  logic [NUM_CPU-1:0] lowest;
  logic [NUM_CPU-1:0] cpu0_only;
  logic               pin_zero;
  logic               any_cand;

  dr_first_one #(.N(NUM_CPU)) u_lowest (
    .req    (cand),
    .onehot (lowest)
  );

  assign cpu0_only = {{(NUM_CPU-1){1'b0}}, cpu_present[0]};
  assign pin_zero  = (src_pin == '0);
  assign any_cand  = |cand;

  always_comb begin
    sel_mask = '0;
    sel_nmi  = 1'b0;
    if (any_cand) begin
      case (dlv_mode)
        DM_FIXED:  sel_mask = pin_zero ? cpu0_only : cand;
        DM_LOWEST: sel_mask = pin_zero ? cpu0_only : lowest;
        DM_NMI: begin
          sel_mask = cand;
          sel_nmi  = 1'b1;
        end
        default: sel_mask = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver #(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 8,
  parameter int PIN_W   = 5,
  parameter int VEC_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ID_W-1:0]         dest_id,
  input  logic                    dest_logical,
  input  logic [2:0]              dlv_mode,
  input  logic [PIN_W-1:0]        src_pin,
  input  logic [VEC_W-1:0]        vector,
  input  logic [NUM_CPU-1:0]      cpu_present,
  input  logic [NUM_CPU*ID_W-1:0] cpu_phys_id,
  input  logic [NUM_CPU*ID_W-1:0] cpu_log_id,
  output logic                    res_valid,
  output logic [NUM_CPU-1:0]      res_mask,
  output logic                    res_nmi,
  output logic                    res_delivered,
  output logic [VEC_W-1:0]        res_vector
);
  logic [NUM_CPU-1:0] cand;
  logic [NUM_CPU-1:0] sel_mask;
  logic               sel_nmi;
  logic               sel_any;

  dr_target_match #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_match (
    .dest_id      (dest_id),
    .dest_logical (dest_logical),
    .cpu_present  (cpu_present),
    .cpu_phys_id  (cpu_phys_id),
    .cpu_log_id   (cpu_log_id),
    .cand         (cand)
  );

  dr_mode_select #(.NUM_CPU(NUM_CPU), .PIN_W(PIN_W)) u_select (
    .cand        (cand),
    .dlv_mode    (dlv_mode),
    .src_pin     (src_pin),
    .cpu_present (cpu_present),
    .sel_mask    (sel_mask),
    .sel_nmi     (sel_nmi)
  );

  assign sel_any = |sel_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_mask      <= '0;
      res_nmi       <= 1'b0;
      res_delivered <= 1'b0;
      res_vector    <= '0;
    end else begin
      res_valid     <= req_valid;
      res_mask      <= req_valid ? sel_mask : '0;
      res_nmi       <= req_valid && sel_nmi && sel_any;
      res_delivered <= req_valid && sel_any;
      res_vector    <= (req_valid && sel_any) ? vector : '0;
    end
  end
endmodule

// File: rtl/intr_dest_resolver_chk.sv
module intr_dest_resolver_chk #(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 8,
  parameter int PIN_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ID_W-1:0]    dest_id,
  input logic               dest_logical,
  input logic [2:0]         dlv_mode,
  input logic [PIN_W-1:0]   src_pin,
  input logic [NUM_CPU-1:0] cpu_present,
  input logic               res_valid,
  input logic [NUM_CPU-1:0] res_mask,
  input logic               res_nmi,
  input logic               res_delivered
);
  import dr_pkg::*;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_mask == '0 && !res_nmi && !res_delivered));

  p_only_present_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((res_mask & ~$past(cpu_present)) == '0));

  p_phys_single_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && !dest_logical && dest_id != {ID_W{1'b1}}
          && dlv_mode == DM_FIXED && src_pin != '0) |-> $onehot0(res_mask));

  p_logical_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && dest_logical && dest_id == '0) |-> (res_mask == '0 && !res_delivered));

  p_lowest_one_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && dlv_mode == DM_LOWEST) |-> $onehot0(res_mask));

  p_nmi_mode_r10: assert property (@(posedge clk) disable iff (rst)
    res_nmi |-> $past(dlv_mode == DM_NMI));

  p_bad_mode_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && dlv_mode != DM_FIXED && dlv_mode != DM_LOWEST && dlv_mode != DM_NMI)
      |-> (res_mask == '0 && !res_delivered && !res_nmi));

  p_delivered_mask_r12: assert property (@(posedge clk) disable iff (rst)
    res_delivered == (res_mask != '0));
endmodule

bind intr_dest_resolver intr_dest_resolver_chk #(
  .NUM_CPU (NUM_CPU),
  .ID_W    (ID_W),
  .PIN_W   (PIN_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .dest_id       (dest_id),
  .dest_logical  (dest_logical),
  .dlv_mode      (dlv_mode),
  .src_pin       (src_pin),
  .cpu_present   (cpu_present),
  .res_valid     (res_valid),
  .res_mask      (res_mask),
  .res_nmi       (res_nmi),
  .res_delivered (res_delivered)
);

// File: tb/test_intr_dest_resolver.sv
`timescale 1ns/1ps
module test_intr_dest_resolver;
  localparam int NC = 4;
  localparam int IW = 8;
  localparam int PW = 5;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [IW-1:0] dest_id = '0;
  logic          dest_logical = 1'b0;
  logic [2:0]    dlv_mode = '0;
  logic [PW-1:0] src_pin = '0;
  logic [VW-1:0] vector = '0;
  logic [NC-1:0] cpu_present = '0;
  logic [NC*IW-1:0] cpu_phys_id;
  logic [NC*IW-1:0] cpu_log_id;
  logic          res_valid;
  logic [NC-1:0] res_mask;
  logic          res_nmi;
  logic          res_delivered;
  logic [VW-1:0] res_vector;

  int total = 0;
  int bad = 0;

  logic [IW-1:0] phys_tab [NC];
  logic [IW-1:0] log_tab  [NC];

  always #4 clk = ~clk;

  initial begin
    phys_tab[0] = 8'h05; phys_tab[1] = 8'h02; phys_tab[2] = 8'h05; phys_tab[3] = 8'h09;
    log_tab[0]  = 8'h01; log_tab[1]  = 8'h02; log_tab[2]  = 8'h06; log_tab[3]  = 8'h80;
  end

  assign cpu_phys_id = {8'h09, 8'h05, 8'h02, 8'h05};
  assign cpu_log_id  = {8'h80, 8'h06, 8'h02, 8'h01};

  intr_dest_resolver #(.NUM_CPU(NC), .ID_W(IW), .PIN_W(PW), .VEC_W(VW)) i_intr_dest_resolver (
    .clk (clk), .rst (rst), .req_valid (req_valid), .dest_id (dest_id),
    .dest_logical (dest_logical), .dlv_mode (dlv_mode), .src_pin (src_pin),
    .vector (vector), .cpu_present (cpu_present), .cpu_phys_id (cpu_phys_id),
    .cpu_log_id (cpu_log_id), .res_valid (res_valid), .res_mask (res_mask),
    .res_nmi (res_nmi), .res_delivered (res_delivered), .res_vector (res_vector)
  );

  function automatic logic [IW-1:0] dest_pick(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h05;
      3: return 8'h09;
      4: return 8'hFF;
      5: return 8'h04;
      6: return 8'h80;
      default: return 8'h03;
    endcase
  endfunction

  function automatic logic [NC-1:0] model_cand(input logic [IW-1:0] d, input logic lg,
                                               input logic [NC-1:0] pr);
    logic [NC-1:0] r = '0;
    if (!lg) begin
      if (d == 8'hFF) r = pr;
      else for (int i = NC-1; i >= 0; i--) if (pr[i] && phys_tab[i] == d) r = NC'(1) << i;
    end else if (d != 0) begin
      for (int i = 0; i < NC; i++) if (pr[i] && (log_tab[i] & d) != 0) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    check("R1", {res_valid, res_mask, res_nmi, res_delivered, res_vector},
          {1'b0, 4'h0, 1'b0, 1'b0, 8'h00});
    rst = 1'b0;
    @(negedge clk);
    // R2: idle cycle gives quiet outputs
    check("R2 idle", {res_valid, res_mask, res_nmi, res_delivered, res_vector}, '0);

    for (int pr = 0; pr < 16; pr++)
      for (int lg = 0; lg < 2; lg++)
        for (int dk = 0; dk < 8; dk++)
          for (int md = 0; md < 8; md++)
            for (int pn = 0; pn < 2; pn++) begin
              logic [IW-1:0] d;
              logic [NC-1:0] cand, emask;
              logic [VW-1:0] vv;
              logic pz, enmi, edel;
              string tag;
              d  = dest_pick(dk);
              pz = (pn == 0);
              vv = VW'(8'h20 + pr + md * 16);
              cand = model_cand(d, lg[0], pr[NC-1:0]);
              emask = '0;
              if (cand != 0) begin
                if (md == 0) emask = pz ? {3'b000, pr[0]} : cand;
                else if (md == 1) emask = pz ? {3'b000, pr[0]} : (cand & (~cand + 4'd1));
                else if (md == 4) emask = cand;
              end
              enmi = (md == 4) && (cand != 0);
              edel = (emask != 0);
              if (md != 0 && md != 1 && md != 4) tag = "R11";
              else if (cand == 0) tag = "R6";
              else if (md == 4) tag = lg ? "R10 R5" : (d == 8'hFF ? "R10 R3" : "R10 R4");
              else if (md == 1) tag = "R9";
              else tag = pz ? "R8" : "R7";

              req_valid    = 1'b1;
              dest_id      = d;
              dest_logical = lg[0];
              dlv_mode     = 3'(md);
              src_pin      = pz ? '0 : PW'(5);
              vector       = vv;
              cpu_present  = pr[NC-1:0];
              @(negedge clk);
              check(tag, {res_valid, res_mask, res_nmi}, {1'b1, emask, enmi});
              check("R12", {res_delivered, res_vector}, {edel, edel ? vv : 8'h00});
            end

    req_valid = 1'b0;
    @(negedge clk);
    check("R2 drop", {res_valid, res_mask, res_nmi, res_delivered, res_vector}, '0);
    // R1: reset in the middle of traffic
    req_valid = 1'b1; dlv_mode = 3'b100; dest_logical = 1'b0; dest_id = 8'hFF; cpu_present = 4'hF;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid", {res_valid, res_mask, res_nmi, res_delivered, res_vector}, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule